// File: doc/BRIEF.md
# Fall-Through Word Queue

This block is a small synchronous first-in first-out queue for 16-bit words. Its storage is a 16-location register file with a synchronous write port and an asynchronous read port. A single command pair drives it. With `en` and `wr` both high the queue stores `din`. With `en` high and `wr` low it discards the oldest word.

The oldest word is presented on `dout` combinationally, without waiting for a clock edge. A consumer can therefore take the word and issue the pop in the same cycle.

Occupancy is reported as a 4-bit `level`, together with registered `empty` and `full` flags. Because the count must fit in 4 bits, at most 15 words are held. Reset is synchronous, and a push and a pop in the same cycle are not supported.

Top module: `ffq_fwft`

## Requirements
- R1: A cycle with `rst`=1 leaves `empty`=1, `full`=0 and `level`=0 after that rising edge, whatever the command inputs are.
- R2: `en`=1, `wr`=1 with `full`=0 stores `din` and raises `level` by one at the next rising edge.
- R3: `en`=1, `wr`=0 with `empty`=0 removes the oldest word and lowers `level` by one at the next rising edge.
- R4: While `empty`=0, `dout` equals the oldest stored word, settled before the edge that would pop it; words leave in the order they arrived.
- R5: `full` rises on the edge where `level` becomes 15, and 15 is the largest level reached.
- R6: `empty` rises on the edge where `level` returns to 0 and falls on the edge after the first push into an empty queue.
- R7: A push while `full`=1 is ignored: `level` and flags stay unchanged and the stored words and their order are unaffected.
- R8: A pop while `empty`=1 is ignored: `level` stays 0 and a later push is the next word presented on `dout`.
- R9: Any pop accepted while `full`=1 clears `full` at the next rising edge.
- R10: With `en`=0 nothing changes, whatever the value of `wr`.
- R11: The internal pointers wrap modulo 16, so ordering holds across any number of words passed through.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Command enable |
| wr | input | 1 | 1 selects push, 0 selects pop, when `en`=1 |
| din | input | 16 | Word to store on a push |
| dout | output | 16 | Oldest stored word, valid while `empty`=0 |
| empty | output | 1 | Registered, queue holds no words |
| full | output | 1 | Registered, queue holds 15 words |
| level | output | 4 | Registered word count, 0 to 15 |

## Verification
The bench aims at the fill boundary, where a design with an off-by-one limit would either raise `full` at 16 and overwrite the oldest word, or refuse the fifteenth word. It issues pops on an empty queue and pushes on a full one. A design that let either command move a pointer would present a stale or skipped word on `dout` afterwards. Long random traffic makes the pointers wrap many times, which exposes wrong pointer widths through out-of-order words. The bench also samples `dout` before each popping edge, which catches a design that registered the read.

// File: rtl/ffq_pkg.sv
package ffq_pkg;

    localparam int FFQ_DW = 16;
    localparam int FFQ_AW = 4;

    typedef enum logic [1:0] {
        FFQ_IDLE = 2'b00,
        FFQ_PUSH = 2'b01,
        FFQ_POP  = 2'b10
    } ffq_cmd_e;

    function automatic ffq_cmd_e ffq_decode(input logic en, input logic wr);
        if (!en)
            return FFQ_IDLE;
        return wr ? FFQ_PUSH : FFQ_POP;
    endfunction

endpackage

// File: rtl/ffq_mem.sv
module ffq_mem #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] word_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(i)))
                word_q[i] <= wdata;
        end
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/ffq_ctrl.sv
module ffq_ctrl
    import ffq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  ffq_cmd_e      cmd,
    output logic          mem_we,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          empty,
    output logic          full,
    output logic [AW-1:0] level
);
    localparam logic [AW-1:0] CAP = {AW{1'b1}};
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW-1:0] cnt;
        logic          empty;
        logic          full;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  push_ok, pop_ok;

    always_comb begin
        push_ok = (cmd == FFQ_PUSH) && !st_q.full;
        pop_ok  = (cmd == FFQ_POP) && !st_q.empty;
        st_d    = st_q;
        if (rst) begin
            st_d       = '0;
            st_d.empty = 1'b1;
            push_ok    = 1'b0;
        end else if (push_ok) begin
            st_d.wptr  = st_q.wptr + ONE;
            st_d.cnt   = st_q.cnt + ONE;
            st_d.empty = 1'b0;
            st_d.full  = (st_q.cnt == CAP - ONE);
        end else if (pop_ok) begin
            st_d.rptr  = st_q.rptr + ONE;
            st_d.cnt   = st_q.cnt - ONE;
            st_d.full  = 1'b0;
            st_d.empty = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mem_we = push_ok;
    assign wptr   = st_q.wptr;
    assign rptr   = st_q.rptr;
    assign empty  = st_q.empty;
    assign full   = st_q.full;
    assign level  = st_q.cnt;

endmodule

// File: rtl/ffq_fwft.sv
module ffq_fwft
    import ffq_pkg::*;
#(
    parameter int DW = FFQ_DW,
    parameter int AW = FFQ_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic [AW-1:0] level
);
    ffq_cmd_e      cmd;
    logic          mem_we;
    logic [AW-1:0] wptr, rptr;

    assign cmd = ffq_decode(en, wr);

    ffq_ctrl #(.AW(AW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mem_we (mem_we),
        .wptr   (wptr),
        .rptr   (rptr),
        .empty  (empty),
        .full   (full),
        .level  (level)
    );

    ffq_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (wptr),
        .wdata  (din),
        .raddr  (rptr),
        .rdata  (dout)
    );

endmodule

// File: rtl/ffq_fwft_chk.sv
module ffq_fwft_chk #(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          wr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic          empty,
    input logic          full,
    input logic [AW-1:0] level
);
    localparam logic [AW-1:0] CAP = {AW{1'b1}};
    localparam logic [AW-1:0] ONE = AW'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (empty && !full && level == '0));

    // R2
    push_count_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr && !full) |=> (level == $past(level) + ONE));

    // R3
    pop_count_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wr && !empty) |=> (level == $past(level) - ONE));

    // R5
    full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr && level == CAP - ONE) |=> full);

    // R6
    empty_level_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !wr && level == ONE) |=> empty);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (full && en && wr) |=> (full && $stable(level)));

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && en && !wr) |=> (empty && level == '0));

    // R9
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (full && en && !wr) |=> !full);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(level) && $stable(empty) && $stable(full)));

endmodule

bind ffq_fwft ffq_fwft_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .wr    (wr),
    .din   (din),
    .dout  (dout),
    .empty (empty),
    .full  (full),
    .level (level)
);

// File: tb/ffq_fwft_bench.sv
`timescale 1ns/1ps
module ffq_fwft_bench;
    localparam int CAPW = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        wr  = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        empty, full;
    logic [3:0]  level;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] mq [16];
    int mhead = 0, mtail = 0, mcnt = 0;

    always #10 clk = ~clk;

    ffq_fwft u_ffq_fwft (
        .clk(clk), .rst(rst), .en(en), .wr(wr), .din(din),
        .dout(dout), .empty(empty), .full(full), .level(level)
    );

    function automatic logic [15:0] model_head();
        return mq[mhead];
    endfunction

    function automatic bit exp_empty();
        return mcnt == 0;
    endfunction

    function automatic bit exp_full();
        return mcnt == CAPW;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mhead = 0; mtail = 0; mcnt = 0;
    endtask

    task automatic check_flags(input string tag);
        chk(level == 4'(mcnt), tag, "level", int'(level), mcnt);
        chk(empty == exp_empty(), tag, "empty", int'(empty), int'(exp_empty()));
        chk(full == exp_full(), tag, "full", int'(full), int'(exp_full()));
    endtask

    // called at a negative edge; returns at the next negative edge
    task automatic step(input bit e, input bit w, input logic [15:0] d,
                        input string tag);
        en = e; wr = w; din = d;
        #1;
        if (mcnt > 0)
            chk(dout == model_head(), "R4", "dout head", int'(dout), int'(model_head()));
        @(posedge clk);
        if (e && w && mcnt < CAPW) begin
            mq[mtail] = d; mtail = (mtail + 1) % 16; mcnt++;
        end else if (e && !w && mcnt > 0) begin
            mhead = (mhead + 1) % 16; mcnt--;
        end
        @(negedge clk);
        check_flags(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b1; wr = 1'b1; din = 16'hdead;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        check_flags("R1");
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R8: pops on empty are ignored and disturb nothing
        step(1, 0, 16'h0, "R8");
        step(1, 0, 16'h0, "R8");
        step(1, 1, 16'ha5a5, "R6");
        #1 chk(dout == 16'ha5a5, "R8", "dout after underflow", int'(dout), 32'ha5a5);

        // R10: disabled cycles change nothing
        step(0, 1, 16'h1111, "R10");
        step(0, 0, 16'h2222, "R10");
        step(1, 0, 16'h0, "R6");

        // R5: fill to capacity
        for (int i = 0; i < CAPW; i++)
            step(1, 1, 16'h1000 + 16'(i), "R5");
        chk(full == 1'b1 && level == 4'd15, "R5", "full at 15", int'(level), 15);

        // R7: pushes while full are ignored
        step(1, 1, 16'hbeef, "R7");
        step(1, 1, 16'hcafe, "R7");

        // R9: first pop from full clears full
        step(1, 0, 16'h0, "R9");
        chk(full == 1'b0, "R9", "full cleared", int'(full), 0);

        // drain, order checked by R4 sampling; R6 at the end
        for (int i = 1; i < CAPW; i++)
            step(1, 0, 16'h0, "R6");
        chk(empty == 1'b1, "R6", "empty after drain", int'(empty), 1);

        // R11: many words through to wrap the pointers
        for (int i = 0; i < 40; i++) begin
            step(1, 1, 16'h4000 + 16'(i), "R11");
            step(1, 1, 16'h5000 + 16'(i), "R11");
            step(1, 0, 16'h0, "R11");
        end
        for (int i = 0; i < 16; i++)
            step(1, 0, 16'h0, "R11");

        // reset mid-stream
        for (int i = 0; i < 5; i++)
            step(1, 1, 16'h7000 + 16'(i), "R2");
        do_reset();

        // random traffic, R2 and R3
        for (int i = 0; i < 4000; i++) begin
            bit e, w;
            e = ($urandom % 8) != 0;
            w = (i % 600 < 300) ? (($urandom % 3) != 0) : (($urandom % 3) == 0);
            step(e, w, 16'($urandom), w ? "R2" : "R3");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule